// File: doc/BRIEF.md
# Command Stream Parser

This block walks a ring of 32-bit command words held in memory. It reads from its own read pointer (GET) up to a write pointer (PUT) that a host moves. A method header expands into a run of (register address, data) pairs on an output stream that has a ready input. Each header carries a word count and a flag that either steps the register address by 4 per data word or holds it fixed. Flow-control words redirect fetching: a jump, a call that uses a single return slot, and a return. A jump whose target is its own address is treated as an idle spin.

Memory is read through a request port with a valid/ready handshake. The response comes back on a separate valid strobe, and only one read is in flight at a time. A two-bit status output reports busy, empty, no-op and error. After an error the parser stays halted until the host pulses a recover input that supplies a fresh GET. The host sees GET through a published copy, which is refreshed at defined points.

Top module: `cmdstream_parser`

## Requirements
- R1: After reset GET is 0, the published GET is 0, no pair is offered, and with PUT at 0 the status is EMPTY. The status encoding is 0 busy, 1 empty, 2 no-op, 3 error.
- R2: A method header has bits 31, 29, 17, 16, 1 and 0 all clear. Its count is bits [28:18] and its register byte address is bits [15:2] with two zero low bits. With bit 30 clear, each later data word goes to an address 4 higher than the word before. With bit 30 set, every data word goes to the same address.
- R3: A method header with count 0 emits no pair, advances GET by 4, and shows status 2 for one cycle.
- R4: When GET equals PUT with PUT's two low bits ignored, no memory read is issued and status is 1. Fetching resumes once PUT moves.
- R5: If PUT stops a burst partway, the remaining count and the current register are kept. The burst continues with the next address when more words arrive.
- R6: A word with bits [31:29]=001 and bits [1:0]=00 is a jump. Fetching continues at the byte address {bits [28:2], 00}.
- R7: A word with bits [1:0]=10 is a call to {bits [31:2], 00} and stores GET+4 in the return slot. A call while the slot is full sets status 3.
- R8: The word 0x00020000 is a return. It reloads GET from the slot and empties the slot. A return while the slot is empty sets status 3.
- R9: A jump to its own address raises the spinning output. The sync request output pulses for exactly one cycle, on entry to the spin only. Spinning clears once the word at that address no longer holds a jump to itself.
- R10: Any other word with one of bits 31, 29, 17, 16, 1 or 0 set is malformed. It sets status 3 and emits no pair.
- R11: Status 3 holds until a recover pulse. The pulse loads GET from the recover value with its low two bits cleared, empties the return slot and resumes fetching.
- R12: The published GET takes the current GET when a burst's last pair is accepted, after a no-op, after a jump, call or return, and while waiting on an empty ring.
- R13: While an offered pair is not accepted, its register and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| put_ptr | input | ADDR_W | Host write pointer (byte address) |
| recover | input | 1 | Recover pulse, used in the error state |
| recover_get | input | ADDR_W | GET value loaded on recover |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | ADDR_W | Read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| out_valid | output | 1 | Pair offered |
| out_ready | input | 1 | Pair accepted |
| out_reg | output | 16 | Register byte address of the pair |
| out_data | output | 32 | Data of the pair |
| status | output | 2 | 0 busy, 1 empty, 2 no-op, 3 error |
| spinning | output | 1 | Parked on a jump to self |
| sync_req | output | 1 | One-cycle pulse on entering a spin |
| get_pub | output | ADDR_W | Host-visible copy of GET |

## Verification
The burst expansion is driven three ways. A stepping burst with a free output shows the address advancing by 4. A fixed-address burst under throttled ready separates the two modes and exposes any loss of a held pair. A burst cut by PUT partway and then extended shows whether the count and address survive the stall. Flow control is tried with a clean call and return that interleaves subroutine pairs before main-stream pairs, a nested call, an unmatched return after recovery, a malformed word, and a self-jump. The self-jump is later overwritten, which distinguishes a real spin from a stuck fetch.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;

  localparam int CNT_W = 11;
  localparam int REG_W = 16;
  localparam logic [31:0] RET_WORD = 32'h0002_0000;

  typedef enum logic [2:0] {K_METHOD, K_JUMP, K_CALL, K_RET, K_BAD} hdr_kind_e;
  typedef enum logic [1:0] {ST_BUSY = 2'd0, ST_EMPTY = 2'd1, ST_NOP = 2'd2, ST_ERROR = 2'd3} pstat_e;
  typedef enum logic [1:0] {S_FETCH, S_WAIT, S_EMIT, S_ERR} fsm_e;

  function automatic hdr_kind_e classify(input logic [31:0] w);
    if (w[1:0] == 2'b10) return K_CALL;
    if (w[31:29] == 3'b001 && w[1:0] == 2'b00) return K_JUMP;
    if (w == RET_WORD) return K_RET;
    if (w[31] | w[29] | w[17] | w[16] | w[1] | w[0]) return K_BAD;
    return K_METHOD;
  endfunction

  function automatic logic [CNT_W-1:0] hdr_count(input logic [31:0] w);
    return w[28:18];
  endfunction

  function automatic logic [REG_W-1:0] hdr_reg(input logic [31:0] w);
    return {w[15:2], 2'b00};
  endfunction

  function automatic logic [31:0] flow_target(input logic [31:0] w);
    if (w[1:0] == 2'b10) return {w[31:2], 2'b00};
    return {3'b000, w[28:2], 2'b00};
  endfunction

  function automatic logic [REG_W-1:0] next_reg(input logic [REG_W-1:0] r, input logic inc);
    return inc ? r + REG_W'(4) : r;
  endfunction

endpackage

// File: rtl/cmdp_decode.sv
module cmdp_decode
  import cmdp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [31:0]       word,
  output hdr_kind_e         kind,
  output logic [CNT_W-1:0]  cnt,
  output logic [REG_W-1:0]  reg_a,
  output logic              ninc,
  output logic [ADDR_W-1:0] tgt
);
  logic [31:0] tgt_full;

  always_comb begin
    kind     = classify(word);
    cnt      = hdr_count(word);
    reg_a    = hdr_reg(word);
    ninc     = word[30];
    tgt_full = flow_target(word);
    tgt      = tgt_full[ADDR_W-1:0];
  end
endmodule

// File: rtl/cmdp_burst.sv
module cmdp_burst
  import cmdp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic [REG_W-1:0] load_reg,
  input  logic             load_inc,
  input  logic             step,
  input  logic             clear,
  output logic [CNT_W-1:0] rem,
  output logic [REG_W-1:0] cur_reg,
  output logic             inc,
  output logic             active,
  output logic             last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem     <= '0;
      cur_reg <= '0;
      inc     <= 1'b1;
    end else if (clear) begin
      rem <= '0;
    end else if (load) begin
      rem     <= load_cnt;
      cur_reg <= load_reg;
      inc     <= load_inc;
    end else if (step && rem != '0) begin
      rem     <= rem - CNT_W'(1);
      cur_reg <= next_reg(cur_reg, inc);
    end
  end

  assign active = (rem != '0);
  assign last   = (rem == CNT_W'(1));
endmodule

// File: rtl/cmdp_retslot.sv
module cmdp_retslot #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop,
  input  logic              clear,
  output logic              valid,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
    end else if (clear || pop) begin
      valid <= 1'b0;
    end else if (push) begin
      valid <= 1'b1;
      addr  <= push_addr;
    end
  end
endmodule

// File: rtl/cmdstream_parser.sv
module cmdstream_parser
  import cmdp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] put_ptr,
  input  logic              recover,
  input  logic [ADDR_W-1:0] recover_get,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [REG_W-1:0]  out_reg,
  output logic [31:0]       out_data,
  output logic [1:0]        status,
  output logic              spinning,
  output logic              sync_req,
  output logic [ADDR_W-1:0] get_pub
);
  localparam logic [ADDR_W-1:0] WSTEP = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] ALIGN = ~ADDR_W'(3);

  fsm_e              state_q;
  logic [ADDR_W-1:0] get_q, pub_q;
  logic              spin_q, sync_q, nop_q;
  logic [REG_W-1:0]  oreg_q;
  logic [31:0]       odata_q;

  // decoded fields of the word being returned
  hdr_kind_e         kind;
  logic [CNT_W-1:0]  cnt;
  logic [REG_W-1:0]  reg_a;
  logic              ninc;
  logic [ADDR_W-1:0] tgt;

  // burst tracker and return slot
  logic [CNT_W-1:0]  b_rem;
  logic [REG_W-1:0]  cur_reg;
  logic              b_inc, b_active, b_last;
  logic              ret_valid;
  logic [ADDR_W-1:0] ret_addr;

  // named events
  logic ring_empty, word_take, hdr_take;
  logic ev_load, ev_nop, ev_self, ev_call, ev_ret, out_fire, do_recover;
  logic [ADDR_W-1:0] get_next;

  cmdp_decode #(.ADDR_W(ADDR_W)) dec_i (
    .word(mem_rsp_data), .kind(kind), .cnt(cnt), .reg_a(reg_a), .ninc(ninc), .tgt(tgt)
  );

  assign ring_empty = (get_q == (put_ptr & ALIGN));
  assign word_take  = (state_q == S_WAIT) && mem_rsp_valid;
  assign hdr_take   = word_take && !b_active;
  assign ev_load    = hdr_take && kind == K_METHOD && cnt != '0;
  assign ev_nop     = hdr_take && kind == K_METHOD && cnt == '0;
  assign ev_self    = hdr_take && kind == K_JUMP && tgt == get_q;
  assign ev_call    = hdr_take && kind == K_CALL;
  assign ev_ret     = hdr_take && kind == K_RET;
  assign out_fire   = (state_q == S_EMIT) && out_ready;
  assign do_recover = (state_q == S_ERR) && recover;
  assign get_next   = get_q + WSTEP;

  cmdp_burst burst_i (
    .clk(clk), .rst_n(rst_n), .load(ev_load), .load_cnt(cnt), .load_reg(reg_a),
    .load_inc(!ninc), .step(out_fire), .clear(do_recover),
    .rem(b_rem), .cur_reg(cur_reg), .inc(b_inc), .active(b_active), .last(b_last)
  );

  cmdp_retslot #(.ADDR_W(ADDR_W)) slot_i (
    .clk(clk), .rst_n(rst_n), .push(ev_call && !ret_valid), .push_addr(get_next),
    .pop(ev_ret && ret_valid), .clear(do_recover), .valid(ret_valid), .addr(ret_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_FETCH;
      get_q   <= '0;
      pub_q   <= '0;
      spin_q  <= 1'b0;
      sync_q  <= 1'b0;
      nop_q   <= 1'b0;
      oreg_q  <= '0;
      odata_q <= '0;
    end else begin
      sync_q <= 1'b0;
      nop_q  <= 1'b0;
      unique case (state_q)
        S_FETCH: begin
          if (ring_empty) pub_q <= get_q;
          else if (mem_req_ready) state_q <= S_WAIT;
        end
        S_WAIT: begin
          if (mem_rsp_valid) begin
            if (b_active) begin
              oreg_q  <= cur_reg;
              odata_q <= mem_rsp_data;
              state_q <= S_EMIT;
            end else begin
              spin_q  <= ev_self;
              state_q <= S_FETCH;
              unique case (kind)
                K_METHOD: begin
                  get_q <= get_next;
                  if (cnt == '0) begin
                    nop_q <= 1'b1;
                    pub_q <= get_next;
                  end
                end
                K_JUMP: begin
                  get_q <= tgt;
                  pub_q <= tgt;
                  if (ev_self) sync_q <= !spin_q;
                end
                K_CALL: begin
                  if (ret_valid) state_q <= S_ERR;
                  else begin
                    get_q <= tgt;
                    pub_q <= tgt;
                  end
                end
                K_RET: begin
                  if (!ret_valid) state_q <= S_ERR;
                  else begin
                    get_q <= ret_addr;
                    pub_q <= ret_addr;
                  end
                end
                default: state_q <= S_ERR;
              endcase
            end
          end
        end
        S_EMIT: begin
          if (out_ready) begin
            get_q   <= get_next;
            state_q <= S_FETCH;
            if (b_last) pub_q <= get_next;
          end
        end
        S_ERR: begin
          if (recover) begin
            get_q   <= recover_get & ALIGN;
            spin_q  <= 1'b0;
            state_q <= S_FETCH;
          end
        end
        default: state_q <= S_FETCH;
      endcase
    end
  end

  always_comb begin
    if (state_q == S_ERR)                         status = ST_ERROR;
    else if (nop_q)                               status = ST_NOP;
    else if (state_q == S_FETCH && ring_empty)    status = ST_EMPTY;
    else                                          status = ST_BUSY;
  end

  assign mem_req_valid = (state_q == S_FETCH) && !ring_empty;
  assign mem_req_addr  = get_q;
  assign out_valid     = (state_q == S_EMIT);
  assign out_reg       = oreg_q;
  assign out_data      = odata_q;
  assign spinning      = spin_q;
  assign sync_req      = sync_q;
  assign get_pub       = pub_q;
endmodule

// File: rtl/cmdp_checker.sv
module cmdp_checker
  import cmdp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       status,
  input logic             out_valid,
  input logic             out_ready,
  input logic [REG_W-1:0] out_reg,
  input logic [31:0]      out_data,
  input logic             ev_call,
  input logic             ev_ret,
  input logic             ret_valid,
  input logic             recover,
  input logic             out_fire,
  input logic             b_inc,
  input logic [CNT_W-1:0] b_rem,
  input logic [REG_W-1:0] cur_reg,
  input logic             sync_req
);
  assert_call_nest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_call && ret_valid |=> status == ST_ERROR);

  assert_ret_unmatched_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ret && !ret_valid |=> status == ST_ERROR);

  assert_inc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && b_inc && b_rem > CNT_W'(1) |=> cur_reg == $past(cur_reg) + REG_W'(4));

  assert_fixed_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && !b_inc && b_rem > CNT_W'(1) |=> $stable(cur_reg));

  assert_sync_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req |=> !sync_req);

  assert_err_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    status == ST_ERROR && !recover |=> status == ST_ERROR);

  assert_err_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    status == ST_ERROR && recover |=> status != ST_ERROR && !ret_valid);

  assert_pair_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_reg) && $stable(out_data));
endmodule

bind cmdstream_parser cmdp_checker chk_i (
  .clk(clk), .rst_n(rst_n), .status(status), .out_valid(out_valid), .out_ready(out_ready),
  .out_reg(out_reg), .out_data(out_data), .ev_call(ev_call), .ev_ret(ev_ret),
  .ret_valid(ret_valid), .recover(recover), .out_fire(out_fire), .b_inc(b_inc),
  .b_rem(b_rem), .cur_reg(cur_reg), .sync_req(sync_req)
);

// File: tb/cmdstream_parser_tb_top.sv
`timescale 1ns/1ps
module cmdstream_parser_tb_top;
  localparam int AW = 16;
  localparam logic [31:0] RETW = 32'h0002_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] put_ptr = '0, recover_get = '0, mem_req_addr, get_pub;
  logic recover = 1'b0, mem_req_valid, mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0, out_data;
  logic out_valid, out_ready = 1'b1, spinning, sync_req;
  logic [15:0] out_reg;
  logic [1:0] status;

  always #4 clk = ~clk;

  cmdstream_parser #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .put_ptr(put_ptr), .recover(recover), .recover_get(recover_get),
    .mem_req_valid(mem_req_valid), .mem_req_ready(1'b1), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_reg(out_reg), .out_data(out_data), .status(status),
    .spinning(spinning), .sync_req(sync_req), .get_pub(get_pub)
  );

  logic [31:0] mem [256];
  always @(posedge clk) begin
    if (mem_req_valid) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem[mem_req_addr[9:2]];
    end else begin
      mem_rsp_valid <= 1'b0;
    end
  end

  int total = 0, fails = 0, cyc = 0, cap_n = 0, exp_n = 0;
  int sync_cnt = 0, nop_cnt = 0, hold_err = 0;
  bit bp = 1'b0, done = 1'b0, held = 1'b0;
  logic [15:0] cap_reg [64], exp_reg [64], held_reg;
  logic [31:0] cap_data [64], exp_data [64], held_data;
  logic [AW-1:0] wp = '0;

  always @(negedge clk) begin
    cyc++;
    if (held && out_valid && (out_reg != held_reg || out_data != held_data)) hold_err++;
    out_ready = bp ? (cyc % 3 == 0) : 1'b1;
    held = out_valid && !out_ready;
    held_reg = out_reg;
    held_data = out_data;
    if (out_valid && out_ready) begin
      cap_reg[cap_n] = out_reg;
      cap_data[cap_n] = out_data;
      cap_n++;
    end
    if (sync_req) sync_cnt++;
    if (status == 2'd2) nop_cnt++;
  end

  function automatic logic [31:0] mk_method(int cnt, logic [15:0] r, bit fixed);
    return (32'(fixed) << 30) | (32'(cnt) << 18) | {16'h0, r[15:2], 2'b00};
  endfunction
  function automatic logic [31:0] mk_jump(logic [AW-1:0] t);
    return 32'h2000_0000 | (32'(t) & 32'h1FFF_FFFC);
  endfunction
  function automatic logic [31:0] mk_call(logic [AW-1:0] t);
    return (32'(t) & 32'hFFFF_FFFC) | 32'h2;
  endfunction

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, expv);
    end
  endtask

  task automatic put_w(input logic [31:0] w);
    mem[wp[9:2]] = w;
    wp = wp + AW'(4);
  endtask

  task automatic expect_pair(input logic [15:0] r, input logic [31:0] d);
    exp_reg[exp_n] = r;
    exp_data[exp_n] = d;
    exp_n++;
  endtask

  task automatic check_pairs(input string tag);
    check(cap_n == exp_n, {tag, " pair count"}, 32'(cap_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      check(cap_reg[i] == exp_reg[i], {tag, " pair reg"}, 32'(cap_reg[i]), 32'(exp_reg[i]));
      check(cap_data[i] == exp_data[i], {tag, " pair data"}, cap_data[i], exp_data[i]);
    end
  endtask

  task automatic wait_status(input logic [1:0] s, input string tag);
    int run = 0;
    for (int i = 0; i < 3000 && run < 4; i++) begin
      @(negedge clk);
      run = (status == s) ? run + 1 : 0;
    end
    check(run >= 4, {tag, " settle status"}, 32'(status), 32'(s));
  endtask

  task automatic pulse_recover(input logic [AW-1:0] g);
    @(negedge clk);
    recover_get = g;
    recover = 1'b1;
    @(negedge clk);
    recover = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(status == 2'd1, "R1 reset status empty", 32'(status), 32'd1);
    check(get_pub == '0, "R1 reset published get", 32'(get_pub), 32'd0);
    check(out_valid == 1'b0, "R1 reset no pair", 32'(out_valid), 32'd0);
    check(mem_req_valid == 1'b0, "R4 no read when empty", 32'(mem_req_valid), 32'd0);
  endtask

  task automatic t_inc_burst();
    put_w(mk_method(3, 16'h0100, 1'b0));
    put_w(32'hA000_0001); put_w(32'hA000_0002); put_w(32'hA000_0003);
    expect_pair(16'h0100, 32'hA000_0001);
    expect_pair(16'h0104, 32'hA000_0002);
    expect_pair(16'h0108, 32'hA000_0003);
    @(negedge clk);
    put_ptr = wp | AW'(3);
    wait_status(2'd1, "R4 masked put");
    check_pairs("R2 stepping burst");
    check(get_pub == wp, "R12 publish after burst", 32'(get_pub), 32'(wp));
  endtask

  task automatic t_fixed_burst();
    bp = 1'b1;
    put_w(mk_method(2, 16'h0200, 1'b1));
    put_w(32'hB000_0001); put_w(32'hB000_0002);
    expect_pair(16'h0200, 32'hB000_0001);
    expect_pair(16'h0200, 32'hB000_0002);
    @(negedge clk);
    put_ptr = wp;
    wait_status(2'd1, "R2 fixed burst");
    bp = 1'b0;
    check_pairs("R2 fixed burst");
    check(hold_err == 0, "R13 pair held under backpressure", 32'(hold_err), 32'd0);
  endtask

  task automatic t_nop();
    int n0 = nop_cnt;
    put_w(mk_method(0, 16'h0100, 1'b0));
    put_w(mk_method(1, 16'h0010, 1'b0));
    put_w(32'hC000_0001);
    expect_pair(16'h0010, 32'hC000_0001);
    @(negedge clk);
    put_ptr = wp;
    wait_status(2'd1, "R3 nop");
    check(nop_cnt - n0 == 1, "R3 nop status one cycle", 32'(nop_cnt - n0), 32'd1);
    check_pairs("R3 nop emits nothing");
    check(get_pub == wp, "R12 publish after nop run", 32'(get_pub), 32'(wp));
  endtask

  task automatic t_split();
    logic [AW-1:0] mid;
    put_w(mk_method(4, 16'h0300, 1'b0));
    put_w(32'hD000_0001); put_w(32'hD000_0002);
    mid = wp;
    expect_pair(16'h0300, 32'hD000_0001);
    expect_pair(16'h0304, 32'hD000_0002);
    @(negedge clk);
    put_ptr = mid;
    wait_status(2'd1, "R5 split first half");
    check_pairs("R5 split first half");
    check(get_pub == mid, "R12 publish while idle mid-burst", 32'(get_pub), 32'(mid));
    put_w(32'hD000_0003); put_w(32'hD000_0004);
    expect_pair(16'h0308, 32'hD000_0003);
    expect_pair(16'h030C, 32'hD000_0004);
    @(negedge clk);
    put_ptr = wp;
    wait_status(2'd1, "R5 split second half");
    check_pairs("R5 split resumed");
  endtask

  task automatic t_jump();
    put_w(mk_jump(AW'(16'h0100)));
    wp = AW'(16'h0100);
    put_w(mk_method(1, 16'h0044, 1'b0));
    put_w(32'hE000_0001);
    expect_pair(16'h0044, 32'hE000_0001);
    @(negedge clk);
    put_ptr = wp;
    wait_status(2'd1, "R6 jump");
    check_pairs("R6 jump redirect");
    check(get_pub == wp, "R12 publish after jump", 32'(get_pub), 32'(wp));
  endtask

  task automatic t_call_ret();
    logic [AW-1:0] main_wp;
    put_w(mk_call(AW'(16'h0300)));
    put_w(mk_method(1, 16'h0050, 1'b0));
    put_w(32'hF000_0003);
    main_wp = wp;
    wp = AW'(16'h0300);
    put_w(mk_method(2, 16'h0060, 1'b0));
    put_w(32'hF000_0001); put_w(32'hF000_0002);
    put_w(RETW);
    wp = main_wp;
    expect_pair(16'h0060, 32'hF000_0001);
    expect_pair(16'h0064, 32'hF000_0002);
    expect_pair(16'h0050, 32'hF000_0003);
    @(negedge clk);
    put_ptr = wp;
    wait_status(2'd1, "R7 call return");
    check_pairs("R7 R8 call then return");
    check(get_pub == wp, "R8 return resumes after call", 32'(get_pub), 32'(wp));
  endtask

  task automatic t_spin();
    logic [AW-1:0] at = wp;
    int s0 = sync_cnt;
    put_w(mk_jump(at));
    @(negedge clk);
    put_ptr = wp;
    repeat (60) @(negedge clk);
    check(spinning == 1'b1, "R9 spinning raised", 32'(spinning), 32'd1);
    check(sync_cnt - s0 == 1, "R9 single sync pulse", 32'(sync_cnt - s0), 32'd1);
    check(get_pub == at, "R12 publish on spin", 32'(get_pub), 32'(at));
    check(status == 2'd0, "R9 spin status busy", 32'(status), 32'd0);
    mem[wp[9:2]] = 32'h1100_0001;
    mem[at[9:2]] = mk_method(1, 16'h0070, 1'b0);
    wp = wp + AW'(4);
    expect_pair(16'h0070, 32'h1100_0001);
    put_ptr = wp;
    wait_status(2'd1, "R9 spin exit");
    check(spinning == 1'b0, "R9 spinning cleared", 32'(spinning), 32'd0);
    check_pairs("R9 resume after spin");
  endtask

  task automatic t_nested();
    put_w(mk_call(AW'(16'h0340)));
    mem[8'hD0] = mk_call(AW'(16'h0380));
    @(negedge clk);
    put_ptr = wp;
    wait_status(2'd3, "R7 nested call");
    check_pairs("R7 nested call emits nothing");
    repeat (10) @(negedge clk);
    check(status == 2'd3, "R11 error held", 32'(status), 32'd3);
    wp = AW'(16'h0200);
    put_w(RETW);
    put_ptr = wp;
    pulse_recover(AW'(16'h0201));
    wait_status(2'd3, "R8 return after recover");
    check(status == 2'd3, "R11 recover emptied slot so R8 return errors", 32'(status), 32'd3);
    put_w(mk_method(1, 16'h0080, 1'b0));
    put_w(32'h2200_0001);
    expect_pair(16'h0080, 32'h2200_0001);
    put_ptr = wp;
    pulse_recover(AW'(16'h0204));
    wait_status(2'd1, "R11 recover resume");
    check_pairs("R11 resume after recover");
    check(get_pub == wp, "R11 get after recover", 32'(get_pub), 32'(wp));
  endtask

  task automatic t_bad();
    put_w(32'h0002_0004);
    @(negedge clk);
    put_ptr = wp;
    wait_status(2'd3, "R10 malformed");
    check_pairs("R10 malformed emits nothing");
    wp = AW'(16'h0240);
    put_w(mk_method(1, 16'h0090, 1'b0));
    put_w(32'h3300_0001);
    expect_pair(16'h0090, 32'h3300_0001);
    put_ptr = wp;
    pulse_recover(AW'(16'h0240));
    wait_status(2'd1, "R10 recover");
    check_pairs("R10 resume after malformed");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_inc_burst();
    t_fixed_burst();
    t_nop();
    t_split();
    t_jump();
    t_call_ret();
    t_spin();
    t_nested();
    t_bad();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule